// File: doc/BRIEF.md
# UART Interrupt Source Arbiter

This block sits beside the receive and transmit paths of a 16550-style serial port. Each cycle it takes the current status conditions, applies the per-source enables, and picks the one pending cause with the highest rank. It presents that choice as an identification byte and drives a single interrupt request line. Status comes from the surrounding port logic: receive error flags, data-ready, receive FIFO fill level and trigger level, a character-timeout flag, a holding-register-empty flag and modem-line change flags. The FIFOs, the shifters and the baud logic are outside this block.

The block holds the four-bit source enable register and a hidden "transmitter empty pending" flag. Register accesses from the host bus change both. A write to the enable slot loads the enables. A write to the data slot retires a pending transmit-empty cause, and so does a read of the identification slot. The identification byte and the request line are registered, so they follow their inputs one clock later.

Top module: `uart_int_arbiter`

## Requirements
- R1: After reset the identification byte is 0x01, the request line is low and the enable register is 0.
- R2: A write to slot 1 loads bits 3:0 of the write data into the enable register and drops bits 7:4. When the bank-select input is high, writes to slots 0 and 1 have no effect on the enable register or on the pending flag.
- R3: If enable bit 2 is set and any of the four receive error flags is set, the code in bits 3:0 is 0x6, whatever else is pending.
- R4: If enable bit 0 is set and the timeout flag is set, the code is 0xC unless R3 applies. With enable bit 0 clear, the timeout flag is never reported.
- R5: If enable bit 0 is set and data is ready, the code is 0x4 unless R3 or R4 applies. In FIFO mode this also needs the receive count to be at least the trigger level. Outside FIFO mode, data-ready alone is enough.
- R6: The transmit-empty pending flag is set by a slot-1 write while the holding register is empty, and by a rising edge of the holding-empty input. A slot-0 write clears it, and this clear wins over a set in the same cycle. A read of slot 2 also clears it. While the flag is set and enable bit 1 is set, the code is 0x2 unless a higher source applies.
- R7: If enable bit 3 is set and any modem change flag is set, the code is 0x0. This applies only when no other source is reported.
- R8: With no source reported the code is 0x1. The request line is high exactly when the code is not 0x1.
- R9: Bits 7:6 of the identification byte are 11 in FIFO mode and 00 otherwise. Bits 5:4 are always 0.
- R10: The identification byte and the request line reflect the inputs sampled at the previous clock edge. They do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register slot: 0 data, 1 enable, 2 identification |
| altBankSel | input | 1 | When high, slots 0 and 1 address another bank |
| wrData | input | 8 | Write data |
| fifoOn | input | 1 | FIFO mode active |
| lineErr | input | 4 | Receive error flags: overrun, parity, framing, break |
| dataReady | input | 1 | Receive data available |
| rxCount | input | 5 | Receive FIFO fill count |
| rxTrigger | input | 5 | Receive trigger level in characters |
| timeoutPend | input | 1 | Character timeout pending |
| thrEmpty | input | 1 | Transmit holding register empty |
| modemDelta | input | 4 | Modem line change flags |
| enableReg | output | 4 | Current source enables |
| identByte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The priority encoder is tested by raising several sources at once and then removing the top one, step by step. Each step shows that the rank order holds and is not just a one-hot decode. Receive data is tried with the count just below and exactly at the trigger level, in FIFO mode and outside it, which separates the threshold compare from a plain data-ready check. The timeout source is raised with enable bit 0 off, which shows that it shares that enable and has none of its own. The pending flag is driven in turn by an enable write, a rising empty edge, a data write, an identification read and a bank-switched write. This checks every set and clear path separately.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  // Strobes from the bus decoder to the datapath
  typedef struct packed {
    logic ldEnable;   // load enable register
    logic clrByData;  // transmit data written
    logic clrByRead;  // identification read
  } uirq_strobe_t;

  localparam logic [3:0] CODE_NONE  = 4'h1;
  localparam logic [3:0] CODE_LINE  = 4'h6;
  localparam logic [3:0] CODE_TMO   = 4'hC;
  localparam logic [3:0] CODE_RXD   = 4'h4;
  localparam logic [3:0] CODE_THR   = 4'h2;
  localparam logic [3:0] CODE_MODEM = 4'h0;

  // Sources in rank order, index 0 highest
  localparam int NUM_SRC = 5;

  function automatic logic [3:0] srcCode(input int idx);
    case (idx)
      0:       return CODE_LINE;
      1:       return CODE_TMO;
      2:       return CODE_RXD;
      3:       return CODE_THR;
      default: return CODE_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
#(
  parameter int AW = 3,
  parameter logic [AW-1:0] ADDR_DATA   = 0,
  parameter logic [AW-1:0] ADDR_ENABLE = 1,
  parameter logic [AW-1:0] ADDR_IDENT  = 2
) (
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [AW-1:0] regAddr,
  input  logic          altBankSel,
  output uirq_strobe_t  strobe
);

  logic wrMain;
  logic rdOnly;

  // A write takes the bus cycle if both strobes are high
  assign wrMain = regWrEn && !altBankSel;
  assign rdOnly = regRdEn && !regWrEn;

  always_comb begin
    strobe           = '0;
    strobe.ldEnable  = wrMain && (regAddr == ADDR_ENABLE);
    strobe.clrByData = wrMain && (regAddr == ADDR_DATA);
    strobe.clrByRead = rdOnly && (regAddr == ADDR_IDENT);
  end

endmodule

// File: rtl/uirq_dpath.sv
module uirq_dpath
  import uirq_pkg::*;
#(
  parameter int EW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  uirq_strobe_t  strobe,
  input  logic [EW-1:0] enData,
  input  logic          fifoOn,
  input  logic [3:0]    lineErr,
  input  logic          dataReady,
  input  logic [CW-1:0] rxCount,
  input  logic [CW-1:0] rxTrigger,
  input  logic          timeoutPend,
  input  logic          thrEmpty,
  input  logic [3:0]    modemDelta,
  output logic [EW-1:0] enableReg,
  output logic [7:0]    identByte,
  output logic          irq
);

  logic               thrPending;
  logic               thrEmptyQ;
  logic [NUM_SRC-1:0] req;
  logic [3:0]         code;
  logic               rxThresh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enableReg <= '0;
    else if (strobe.ldEnable) enableReg <= enData;
  end

  // Hidden transmit-empty pending flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrEmptyQ  <= 1'b1;
      thrPending <= 1'b0;
    end else begin
      thrEmptyQ <= thrEmpty;
      if (strobe.clrByData) thrPending <= 1'b0;
      else if ((strobe.ldEnable && thrEmpty) || (thrEmpty && !thrEmptyQ))
        thrPending <= 1'b1;
      else if (strobe.clrByRead) thrPending <= 1'b0;
    end
  end

  assign rxThresh = !fifoOn || (rxCount >= rxTrigger);

  always_comb begin
    req    = '0;
    req[0] = enableReg[2] && (|lineErr);
    req[1] = enableReg[0] && timeoutPend;
    req[2] = enableReg[0] && dataReady && rxThresh;
    req[3] = enableReg[1] && thrPending;
    req[4] = enableReg[3] && (|modemDelta);
  end

  // Scan lowest rank first so the highest asserted rank wins
  always_comb begin
    code = CODE_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) code = srcCode(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      identByte <= {4'h0, CODE_NONE};
      irq       <= 1'b0;
    end else begin
      identByte <= {{2{fifoOn}}, 2'b00, code};
      irq       <= (code != CODE_NONE);
    end
  end

endmodule

// File: rtl/uart_int_arbiter.sv
module uart_int_arbiter
  import uirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int EN_BITS    = 4,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [2:0]         regAddr,
  input  logic               altBankSel,
  input  logic [7:0]         wrData,
  input  logic               fifoOn,
  input  logic [3:0]         lineErr,
  input  logic               dataReady,
  input  logic [CW-1:0]      rxCount,
  input  logic [CW-1:0]      rxTrigger,
  input  logic               timeoutPend,
  input  logic               thrEmpty,
  input  logic [3:0]         modemDelta,
  output logic [EN_BITS-1:0] enableReg,
  output logic [7:0]         identByte,
  output logic               irq
);

  uirq_strobe_t strobe;
  logic         unusedBits;

  assign unusedBits = ^wrData[7:EN_BITS];

  uirq_ctrl #(.AW(3)) u_ctrl (
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .altBankSel(altBankSel),
    .strobe    (strobe)
  );

  uirq_dpath #(.EW(EN_BITS), .CW(CW)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .enData     (wrData[EN_BITS-1:0]),
    .fifoOn     (fifoOn),
    .lineErr    (lineErr),
    .dataReady  (dataReady),
    .rxCount    (rxCount),
    .rxTrigger  (rxTrigger),
    .timeoutPend(timeoutPend),
    .thrEmpty   (thrEmpty),
    .modemDelta (modemDelta),
    .enableReg  (enableReg),
    .identByte  (identByte),
    .irq        (irq)
  );

endmodule

// File: rtl/uart_int_arbiter_chk.sv
module uart_int_arbiter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [2:0] regAddr,
  input logic       altBankSel,
  input logic       fifoOn,
  input logic [3:0] lineErr,
  input logic [3:0] modemDelta,
  input logic [3:0] enableReg,
  input logic [7:0] identByte,
  input logic       irq
);

  // R8
  a_r8_irq_follows_code: assert property (@(posedge clk) disable iff (!rstN)
    irq == (identByte[3:0] != 4'h1));

  // R3
  a_r3_line_wins: assert property (@(posedge clk) disable iff (!rstN)
    (enableReg[2] && (|lineErr)) |=> identByte[3:0] == 4'h6);

  // R4
  a_r4_timeout_masked: assert property (@(posedge clk) disable iff (!rstN)
    !enableReg[0] |=> identByte[3:0] != 4'hC);

  // R9
  a_r9_fifo_bits: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> identByte[7:4] == {{2{$past(fifoOn)}}, 2'b00});

  // R2
  a_r2_bank_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && altBankSel && regAddr == 3'd1) |=> $stable(enableReg));

  // R7
  a_r7_modem_needs_cause: assert property (@(posedge clk) disable iff (!rstN)
    (identByte[3:0] == 4'h0) |-> $past(enableReg[3] && (|modemDelta)));

endmodule

bind uart_int_arbiter uart_int_arbiter_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .altBankSel(altBankSel),
  .fifoOn    (fifoOn),
  .lineErr   (lineErr),
  .modemDelta(modemDelta),
  .enableReg (enableReg),
  .identByte (identByte),
  .irq       (irq)
);

// File: tb/uart_int_arbiter_tb.sv
`timescale 1ns/1ps
module uart_int_arbiter_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 0, regRdEn = 0, altBankSel = 0;
  logic [2:0] regAddr = 0;
  logic [7:0] wrData = 0;
  logic       fifoOn = 0, dataReady = 0, timeoutPend = 0, thrEmpty = 0;
  logic [3:0] lineErr = 0, modemDelta = 0;
  logic [4:0] rxCount = 0, rxTrigger = 0;
  logic [3:0] enableReg;
  logic [7:0] identByte;
  logic       irq;

  int nChecks = 0;
  int nErrs   = 0;
  bit doneFlag = 0;

  always #2 clk = ~clk;

  uart_int_arbiter u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .altBankSel(altBankSel), .wrData(wrData),
    .fifoOn(fifoOn), .lineErr(lineErr), .dataReady(dataReady),
    .rxCount(rxCount), .rxTrigger(rxTrigger), .timeoutPend(timeoutPend),
    .thrEmpty(thrEmpty), .modemDelta(modemDelta), .enableReg(enableReg),
    .identByte(identByte), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d, input logic bank);
    @(negedge clk);
    regWrEn = 1; regAddr = a; wrData = d; altBankSel = bank;
    @(negedge clk);
    regWrEn = 0; altBankSel = 0;
  endtask

  task automatic busReadIdent();
    @(negedge clk);
    regRdEn = 1; regAddr = 3'd2;
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic testReset();
    check("R1 ident", identByte, 8'h01);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 enable", {4'b0, enableReg}, 8'h00);
  endtask

  task automatic testEnableReg();
    busWrite(3'd1, 8'hF0, 1'b0); settle();
    check("R2 high bits dropped", {4'b0, enableReg}, 8'h00);
    busWrite(3'd1, 8'hFF, 1'b0); settle();
    check("R2 load", {4'b0, enableReg}, 8'h0F);
    busWrite(3'd1, 8'h00, 1'b1); settle();
    check("R2 bank write ignored", {4'b0, enableReg}, 8'h0F);
    check("R8 idle code", identByte, 8'h01);
  endtask

  task automatic testThrPending();
    busWrite(3'd1, 8'h02, 1'b0);
    thrEmpty = 1; settle();
    check("R6 rising empty sets", identByte, 8'h02);
    check("R8 irq high", {7'b0, irq}, 8'h01);
    busReadIdent(); settle();
    check("R6 ident read clears", identByte, 8'h01);
    check("R8 irq low", {7'b0, irq}, 8'h00);
    busWrite(3'd1, 8'h02, 1'b0); settle();
    check("R6 enable write sets", identByte, 8'h02);
    busWrite(3'd0, 8'h55, 1'b1); settle();
    check("R6 bank data write ignored", identByte, 8'h02);
    busWrite(3'd0, 8'h55, 1'b0); settle();
    check("R6 data write clears", identByte, 8'h01);
    thrEmpty = 0;
    busWrite(3'd1, 8'h02, 1'b0); settle();
    check("R6 enable write while full", identByte, 8'h01);
  endtask

  task automatic testModem();
    busWrite(3'd1, 8'h08, 1'b0);
    modemDelta = 4'b0100; settle();
    check("R7 modem code", identByte, 8'h00);
    check("R8 irq for code 0", {7'b0, irq}, 8'h01);
    busWrite(3'd1, 8'h00, 1'b0); settle();
    check("R7 modem disabled", identByte, 8'h01);
  endtask

  task automatic testRxData();
    busWrite(3'd1, 8'h09, 1'b0);
    dataReady = 1; settle();
    check("R5 non-fifo ready", identByte, 8'h04);
    fifoOn = 1; rxTrigger = 5'd4; rxCount = 5'd3; settle();
    check("R5 below trigger", identByte, 8'hC0);
    rxCount = 5'd4; settle();
    check("R5 at trigger, R9 fifo bits", identByte, 8'hC4);
  endtask

  task automatic testTimeout();
    timeoutPend = 1; settle();
    check("R4 timeout over rx data", identByte, 8'hCC);
    busWrite(3'd1, 8'h08, 1'b0); settle();
    check("R4 masked by bit 0", identByte, 8'hC0);
  endtask

  task automatic testLineAndLatency();
    busWrite(3'd1, 8'h0F, 1'b0); settle();
    check("R4 restored", identByte, 8'hCC);
    lineErr = 4'b0010;
    #0.5;
    check("R10 unchanged before edge", identByte, 8'hCC);
    @(posedge clk); @(negedge clk);
    check("R3 line wins, R10 one edge", identByte, 8'hC6);
    busWrite(3'd1, 8'h0B, 1'b0); settle();
    check("R3 masked falls to timeout", identByte, 8'hCC);
    timeoutPend = 0; fifoOn = 0; settle();
    check("R9 non-fifo bits", identByte, 8'h04);
    dataReady = 0; settle();
    check("R7 lowest reached", identByte, 8'h00);
  endtask

  initial begin
    #50_000;
    if (!doneFlag) begin
      nChecks++; nErrs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testEnableReg();
    testThrPending();
    testModem();
    testRxData();
    testTimeout();
    testLineAndLatency();
    doneFlag = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end

endmodule